// File: doc/BRIEF.md
# Dual-Processor Mailbox Register Bridge

This block joins an 8-bit host processor bus to the register port of a second, client processor. Bytes travel both ways through four numbered channels. Each channel pairs one buffer per direction, and each buffer is sized on its own. The client-to-host side of channel 1 is a 24-byte queue. Channel 3 has a 2-byte queue in each direction. Every other buffer holds a single byte. Both ports see the same eight-location window. The even location of a pair reports the channel status. The odd location pops a byte on a read and pushes a byte on a write.

A shared 6-bit control register selects which channels may interrupt the client. The active-low interrupt stays low while any enabled channel holds host-to-client data that the client has not yet read. Both ports share one clock. An access takes place in a cycle where the port's active-low select is low and its strobe is high. The read/write line then picks a read or a write.

Top module: `mbox_bridge`

## Requirements
- R1: After reset every buffer is empty and the control register is zero. `irq_n` is 1, and both read-data outputs are 0.
- R2: The host port decodes only `h_addr[2:0]`. The higher bits of `h_addr` have no effect.
- R3: A port changes nothing in a cycle where its select is high or its strobe is low. Its read data holds its value in such a cycle.
- R4: Locations 2k and 2k+1 (k = 0..3) belong to channel k+1. A read of the even location returns a status byte. Bit 7 is set when this side has data to read from the channel. Bit 6 is set when this side has room to write into it. Bits 5:0 read as 0.
- R5: Client-to-host channel 1 holds up to 24 bytes in first-in first-out order. A write made while it is full is dropped.
- R6: Channel 3 holds up to 2 bytes in first-in first-out order in each direction. A third write is dropped.
- R7: Host-to-client channel 1 and both directions of channels 2 and 4 hold one byte each. A second write before the byte is read is dropped, and the first byte is kept.
- R8: A data read from an empty channel leaves the read data and all buffer state unchanged.
- R9: A write to any even location, from either port, loads data bits 5:0 into the control register. When both ports write the register in the same cycle, the host value wins.
- R10: `irq_n` is 0 while, for some k in 0..3, control bit k is 1 and host-to-client channel k+1 is not empty. It returns to 1 once the client has read that data or the enable is cleared. Control bits 5:4 have no effect.
- R11: The byte for a read appears on the port's read-data output in the cycle after the access. It stays there until that port's next read.
- R12: A push and a pop on the same buffer in the same cycle both take effect. Fullness and emptiness are judged on the state at the start of the cycle, so a push into a buffer that was full is dropped even if a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel_n | input | 1 | Host select, active low |
| h_rnw | input | 1 | Host direction: 1 read, 0 write |
| h_stb | input | 1 | Host access strobe |
| h_addr | input | HOST_AW (8) | Host address; only bits 2:0 decoded |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| c_sel_n | input | 1 | Client select, active low |
| c_rnw | input | 1 | Client direction: 1 read, 0 write |
| c_stb | input | 1 | Client access strobe |
| c_addr | input | 3 | Client window address |
| c_wdata | input | 8 | Client write data |
| c_rdata | output | 8 | Client read data, registered |
| irq_n | output | 1 | Interrupt to client, active low |

## Verification
Two events can fall in the same cycle. One port can push into a buffer while the other pops it, and both ports can write the control register at once. The directed part provokes both. It pops channel 3 from the host while the client pushes into it, once with the queue full and once with one byte in it. It also writes the control register from both sides in one cycle, and the interrupt line then shows which value was kept. The random part drives both ports in every cycle, with random select, strobe, address and data. Its results are compared each cycle against a model that judges fullness on the state at the start of the cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int NCH    = 4;
    localparam int DW     = 8;
    localparam int WIN_AW = 3;
    localparam int CTRL_W = 6;

    typedef logic [DW-1:0] byte_t;

    // buffer depth per channel and direction
    function automatic int chan_depth(input bit to_host, input int ch, input int deep, input int mid);
        if (ch == 0) return to_host ? deep : 1;
        if (ch == 2) return mid;
        return 1;
    endfunction

    function automatic byte_t status_byte(input logic avail, input logic space);
        return {avail, space, {(DW-2){1'b0}}};
    endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DEPTH = 2,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = step_ptr(st_q.wp);
        end
        if (pop) st_d.rp = step_ptr(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    assert_push_has_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_pop_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_pushpop_keeps_cnt_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(st_q.cnt));
endmodule

// File: rtl/mbox_port.sv
module mbox_port
    import mbox_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n,
    input  logic                  stb,
    input  logic                  rnw,
    input  logic [WIN_AW-1:0]     addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NCH-1:0]        avail,
    input  logic [NCH-1:0]        space,
    input  logic [NCH-1:0][DW-1:0] head,
    output logic [NCH-1:0]        push,
    output logic [NCH-1:0]        pop,
    output logic                  ctrl_we,
    output logic [DW-1:0]         rdata
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     acc;
    logic [1:0] ch;
    logic     is_data;
    logic     unused_wdata;

    assign acc          = !sel_n && stb;
    assign ch           = addr[2:1];
    assign is_data      = addr[0];
    assign unused_wdata = ^wdata;

    always_comb begin
        st_d    = st_q;
        push    = '0;
        pop     = '0;
        ctrl_we = 1'b0;
        if (acc) begin
            if (rnw) begin
                if (!is_data)        st_d.rdata = status_byte(avail[ch], space[ch]);
                else if (avail[ch]) begin
                    st_d.rdata = head[ch];
                    pop[ch]    = 1'b1;
                end
            end else begin
                if (!is_data)        ctrl_we  = 1'b1;
                else if (space[ch])  push[ch] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    assert_idle_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> (push == '0 && pop == '0 && !ctrl_we));
    assert_rdata_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && rnw) |=> $stable(rdata));
    assert_one_hot_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, pop, ctrl_we}));
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int HOST_AW  = 8,
    parameter int DEEP_LEN = 24,
    parameter int MID_LEN  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_sel_n,
    input  logic               h_rnw,
    input  logic               h_stb,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic [DW-1:0]      h_wdata,
    output logic [DW-1:0]      h_rdata,
    input  logic               c_sel_n,
    input  logic               c_rnw,
    input  logic               c_stb,
    input  logic [WIN_AW-1:0]  c_addr,
    input  logic [DW-1:0]      c_wdata,
    output logic [DW-1:0]      c_rdata,
    output logic               irq_n
);
    logic [NCH-1:0]         h2c_push, h2c_pop, h2c_empty, h2c_full;
    logic [NCH-1:0]         c2h_push, c2h_pop, c2h_empty, c2h_full;
    logic [NCH-1:0][DW-1:0] h2c_head, c2h_head;
    logic                   h_ctrl_we, c_ctrl_we;
    logic                   unused_hi_addr;

    assign unused_hi_addr = ^h_addr[HOST_AW-1:WIN_AW];

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        mbox_fifo #(.DEPTH(chan_depth(1'b0, k, DEEP_LEN, MID_LEN)), .DW(DW)) u_to_client (
            .clk(clk), .rst_n(rst_n), .push(h2c_push[k]), .pop(h2c_pop[k]),
            .wdata(h_wdata), .head(h2c_head[k]), .empty(h2c_empty[k]), .full(h2c_full[k]));
        mbox_fifo #(.DEPTH(chan_depth(1'b1, k, DEEP_LEN, MID_LEN)), .DW(DW)) u_to_host (
            .clk(clk), .rst_n(rst_n), .push(c2h_push[k]), .pop(c2h_pop[k]),
            .wdata(c_wdata), .head(c2h_head[k]), .empty(c2h_empty[k]), .full(c2h_full[k]));
    end

    mbox_port u_host (
        .clk(clk), .rst_n(rst_n), .sel_n(h_sel_n), .stb(h_stb), .rnw(h_rnw),
        .addr(h_addr[WIN_AW-1:0]), .wdata(h_wdata),
        .avail(~c2h_empty), .space(~h2c_full), .head(c2h_head),
        .push(h2c_push), .pop(c2h_pop), .ctrl_we(h_ctrl_we), .rdata(h_rdata));

    mbox_port u_client (
        .clk(clk), .rst_n(rst_n), .sel_n(c_sel_n), .stb(c_stb), .rnw(c_rnw),
        .addr(c_addr), .wdata(c_wdata),
        .avail(~h2c_empty), .space(~c2h_full), .head(h2c_head),
        .push(c2h_push), .pop(h2c_pop), .ctrl_we(c_ctrl_we), .rdata(c_rdata));

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    unused_ctrl_hi;

    always_comb begin
        st_d = st_q;
        if (h_ctrl_we)      st_d.ctrl = h_wdata[CTRL_W-1:0];
        else if (c_ctrl_we) st_d.ctrl = c_wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unused_ctrl_hi = ^st_q.ctrl[CTRL_W-1:NCH];
    assign irq_n = ~|(st_q.ctrl[NCH-1:0] & ~h2c_empty);

    assert_host_ctrl_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ctrl_we && c_ctrl_we) |=> st_q.ctrl == $past(h_wdata[CTRL_W-1:0]));
    assert_irq_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(|h2c_push) || $past(h_ctrl_we || c_ctrl_we)));
    assert_irq_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> ($past(|h2c_pop) || $past(h_ctrl_we || c_ctrl_we)));
endmodule

// File: tb/mbox_bridge_tb_top.sv
module mbox_bridge_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_sel_n = 1'b1, h_rnw = 1'b1, h_stb = 1'b0;
    logic [7:0] h_addr = '0, h_wdata = '0;
    logic       c_sel_n = 1'b1, c_rnw = 1'b1, c_stb = 1'b0;
    logic [2:0] c_addr = '0;
    logic [7:0] c_wdata = '0;
    logic [7:0] h_rdata, c_rdata;
    logic       irq_n;

    always #10 clk = ~clk;

    mbox_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .h_sel_n(h_sel_n), .h_rnw(h_rnw), .h_stb(h_stb), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_sel_n(c_sel_n), .c_rnw(c_rnw), .c_stb(c_stb), .c_addr(c_addr),
        .c_wdata(c_wdata), .c_rdata(c_rdata), .irq_n(irq_n));

    // reference model: mh = host-to-client, mc = client-to-host
    logic [7:0] mh [4][24];
    logic [7:0] mc [4][24];
    int         nh [4];
    int         nc [4];
    logic [5:0] mctrl;
    logic [7:0] eh, ec;
    int         checks = 0, fails = 0;
    bit         done = 0;

    function automatic int depth_of(input bit to_host, input int k);
        if (k == 0) return to_host ? 24 : 1;
        if (k == 2) return 2;
        return 1;
    endfunction

    function automatic logic exp_irq_n();
        for (int k = 0; k < 4; k++) if (mctrl[k] && nh[k] > 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk8(req, "h_rdata", h_rdata, eh);
        chk8(req, "c_rdata", c_rdata, ec);
        chk8(req, "irq_n", {7'd0, irq_n}, {7'd0, exp_irq_n()});
    endtask

    task automatic step(input logic hs_n, input logic hst, input logic hr, input logic [7:0] ha,
                        input logic [7:0] hd, input logic cs_n, input logic cst, input logic cr,
                        input logic [2:0] ca, input logic [7:0] cd, input string req);
        int  hk, ck;
        int  nh0 [4];
        int  nc0 [4];
        bit  hacc, cacc, hpush, hpop, cpush, cpop, hctl, cctl;
        h_sel_n = hs_n; h_stb = hst; h_rnw = hr; h_addr = ha; h_wdata = hd;
        c_sel_n = cs_n; c_stb = cst; c_rnw = cr; c_addr = ca; c_wdata = cd;
        nh0 = nh; nc0 = nc;
        hk = int'(ha[2:1]); ck = int'(ca[2:1]);
        hacc = !hs_n && hst; cacc = !cs_n && cst;
        hpush = 0; hpop = 0; cpush = 0; cpop = 0; hctl = 0; cctl = 0;
        if (hacc) begin
            if (hr) begin
                if (!ha[0]) eh = {nc0[hk] > 0, nh0[hk] < depth_of(0, hk), 6'd0};
                else if (nc0[hk] > 0) begin eh = mc[hk][0]; hpop = 1; end
            end else begin
                if (!ha[0]) hctl = 1;
                else if (nh0[hk] < depth_of(0, hk)) hpush = 1;
            end
        end
        if (cacc) begin
            if (cr) begin
                if (!ca[0]) ec = {nh0[ck] > 0, nc0[ck] < depth_of(1, ck), 6'd0};
                else if (nh0[ck] > 0) begin ec = mh[ck][0]; cpop = 1; end
            end else begin
                if (!ca[0]) cctl = 1;
                else if (nc0[ck] < depth_of(1, ck)) cpush = 1;
            end
        end
        if (hpop) begin
            for (int i = 0; i < 23; i++) mc[hk][i] = mc[hk][i+1];
            nc[hk]--;
        end
        if (cpop) begin
            for (int i = 0; i < 23; i++) mh[ck][i] = mh[ck][i+1];
            nh[ck]--;
        end
        if (hpush) begin mh[hk][nh[hk]] = hd; nh[hk]++; end
        if (cpush) begin mc[ck][nc[ck]] = cd; nc[ck]++; end
        if (hctl) mctrl = hd[5:0];
        else if (cctl) mctrl = cd[5:0];
        @(posedge clk);
        @(negedge clk);
        check_all(req);
    endtask

    task automatic hwr(input logic [7:0] a, input logic [7:0] d, input string req);
        step(0, 1, 0, a, d, 1, 0, 1, 3'd0, 8'd0, req);
    endtask
    task automatic hrd(input logic [7:0] a, input string req);
        step(0, 1, 1, a, 8'd0, 1, 0, 1, 3'd0, 8'd0, req);
    endtask
    task automatic cwr(input logic [2:0] a, input logic [7:0] d, input string req);
        step(1, 0, 1, 8'd0, 8'd0, 0, 1, 0, a, d, req);
    endtask
    task automatic crd(input logic [2:0] a, input string req);
        step(1, 0, 1, 8'd0, 8'd0, 0, 1, 1, a, 8'd0, req);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin nh[k] = 0; nc[k] = 0; end
        mctrl = '0; eh = '0; ec = '0;
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
        for (int k = 0; k < 4; k++) begin
            hrd(8'(2 * k), "R1");
            crd(3'(2 * k), "R4");
        end
        // R2: upper host address bits ignored
        hwr(8'hF9, 8'h5A, "R2");
        crd(3'd0, "R2");
        crd(3'd1, "R2");
        // R3: no select or no strobe -> no effect
        step(1, 1, 0, 8'h03, 8'h11, 0, 0, 0, 3'd3, 8'h22, "R3");
        step(0, 0, 0, 8'h03, 8'h33, 1, 1, 0, 3'd3, 8'h44, "R3");
        crd(3'd2, "R3");
        hrd(8'h02, "R3");
        // R5: deep queue fill, overflow, drain in order, then empty read
        for (int i = 0; i < 25; i++) cwr(3'd1, 8'(8'h80 + i), "R5");
        hrd(8'h00, "R5");
        crd(3'd0, "R5");
        for (int i = 0; i < 24; i++) hrd(8'h01, "R5");
        hrd(8'h01, "R8");
        hrd(8'h00, "R8");
        // R6: two-deep queues both ways
        for (int i = 0; i < 3; i++) hwr(8'h05, 8'(8'hA0 + i), "R6");
        for (int i = 0; i < 3; i++) cwr(3'd5, 8'(8'hB0 + i), "R6");
        for (int i = 0; i < 3; i++) begin crd(3'd5, "R6"); hrd(8'h05, "R6"); end
        // R7: single-byte latches keep the first byte
        hwr(8'h03, 8'h61, "R7"); hwr(8'h03, 8'h62, "R7");
        cwr(3'd7, 8'h71, "R7"); cwr(3'd7, 8'h72, "R7");
        crd(3'd3, "R7"); hrd(8'h07, "R7"); crd(3'd3, "R8");
        // R9/R10: control and interrupt
        hwr(8'h05, 8'hC1, "R10");
        cwr(3'd0, 8'h04, "R10");
        hwr(8'h05, 8'hC2, "R10");
        crd(3'd5, "R10");
        crd(3'd5, "R10");
        hwr(8'h03, 8'hD1, "R10");
        cwr(3'd6, 8'h30, "R10");
        step(0, 1, 0, 8'h00, 8'h02, 0, 1, 0, 3'd2, 8'h01, "R9");
        step(0, 1, 0, 8'h00, 8'h01, 0, 1, 0, 3'd2, 8'h02, "R9");
        crd(3'd3, "R10");
        // R12: same-cycle push and pop on client-to-host channel 3
        cwr(3'd5, 8'hE0, "R12"); cwr(3'd5, 8'hE1, "R12");
        step(0, 1, 1, 8'h05, 8'h00, 0, 1, 0, 3'd5, 8'hE2, "R12");
        step(0, 1, 1, 8'h05, 8'h00, 0, 1, 0, 3'd5, 8'hE3, "R12");
        hrd(8'h05, "R12"); hrd(8'h05, "R12");
        // random traffic on both ports
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 2) == 0, ($urandom % 4) != 0, ($urandom % 2) == 0, 8'($urandom),
                 8'($urandom), ($urandom % 2) == 0, ($urandom % 4) != 0, ($urandom % 2) == 0,
                 3'($urandom), 8'($urandom), "R11");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule